// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Shared Sticky Overflow

This block holds the two byte queues of an SPI controller in one clock domain. The receive queue is filled by the serial shift logic and emptied by software. The transmit queue is filled by software and emptied by the shift logic. Each queue holds 128 bytes. Each queue reports its occupancy, a full flag and an empty flag.

Every data edge is a valid/ready stream. A queue's input `ready` is high when the queue is not full, or when its output side pops in the same cycle. A producer may raise `valid` while `ready` is low, and it does not have to hold the byte. That beat is dropped: the stored bytes stay as they were, and a single overflow flag shared by both queues is set. On the output side, `valid` means the queue is not empty. A pop happens when `valid` and `ready` are both high. While a queue is empty, its data output keeps showing the last byte popped from it.

The overflow flag stays set until software writes a 1 to it. A write of 0 does nothing. If an overflow and a clearing write fall in the same cycle, the overflow wins and the flag stays set.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both queues are empty, both counts are 0, both data outputs are 0 and the overflow flag is 0.
- R2: Each queue returns bytes in the order they were accepted. It holds up to 128 bytes. Its count equals the number of bytes stored.
- R3: A receive push while the receive queue is full and not popping is discarded: the count and the head byte are unchanged.
- R4: A transmit write while the transmit queue is full and not popping is ignored and adds no data.
- R5: A discarded push on either queue sets the shared overflow flag one cycle later. The flag then stays 1 until it is cleared.
- R6: A clearing write with data bit 1 clears the flag on the next cycle. A clearing write with data bit 0 leaves the flag unchanged.
- R7: When an overflow and a clearing write with bit 1 occur in the same cycle, the flag is 1 on the next cycle.
- R8: A push and a pop in the same cycle on a full queue both take effect. The count stays at 128 and no overflow is flagged.
- R9: A pop from an empty queue is ignored: the count stays 0 and the data output keeps the last popped byte.
- R10: Input `ready` equals (not full) OR output `ready`. Output `valid` equals (count not zero).
- R11: The full flag stays asserted in every cycle until a byte is popped from that queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in_valid | input | 1 | Shift logic offers a received byte |
| rx_in_ready | output | 1 | Receive queue can accept this cycle |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Receive queue not empty |
| rx_out_ready | input | 1 | Software pops the receive queue |
| rx_out_data | output | 8 | Receive head byte, or last popped byte when empty |
| rx_count | output | 8 | Receive occupancy |
| rx_full | output | 1 | Receive queue holds 128 bytes |
| rx_empty | output | 1 | Receive queue holds no byte |
| tx_in_valid | input | 1 | Software writes a byte to send |
| tx_in_ready | output | 1 | Transmit queue can accept this cycle |
| tx_in_data | input | 8 | Byte to send |
| tx_out_valid | output | 1 | Transmit queue not empty |
| tx_out_ready | input | 1 | Shift logic pops the transmit queue |
| tx_out_data | output | 8 | Transmit head byte, or last popped byte when empty |
| tx_count | output | 8 | Transmit occupancy |
| tx_full | output | 1 | Transmit queue holds 128 bytes |
| tx_empty | output | 1 | Transmit queue holds no byte |
| ovf_wr_en | input | 1 | Software write strobe for the overflow flag |
| ovf_wr_bit | input | 1 | Data bit of that write; 1 clears |
| ovf_flag | output | 1 | Shared sticky overflow flag |

## Verification
The assertions check these rules on every cycle:
- the set and hold behaviour of the overflow flag, including the case where a set and a clear arrive together;
- that a count never exceeds the depth;
- that a discarded push leaves the count unchanged;
- that a full flag persists while no byte is popped;
- that a pop from an empty queue leaves the data output unchanged.

Byte ordering, the exact occupancy after mixed traffic, and the behaviour of a queue wrapping around its storage are shown only by the bench scenarios. These scenarios are filling, overflowing, draining past empty, push and pop together on a full queue, and long random traffic compared against a queue model.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned DEFAULT_DEPTH = 128;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = spi_fifo_pkg::DEFAULT_DEPTH,
  parameter int unsigned DW    = spi_fifo_pkg::BYTE_W,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop_evt
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] last_q;
  logic          do_pop, do_push;

  assign full      = (cnt_q == DEPTH_C);
  assign empty     = (cnt_q == '0);
  assign count     = cnt_q;
  assign out_valid = !empty;
  assign do_pop    = out_ready && !empty;
  // a pop in the same cycle frees a slot before the push lands
  assign in_ready  = !full || out_ready;
  assign do_push   = in_valid && in_ready;
  assign drop_evt  = in_valid && !in_ready;
  assign out_data  = empty ? last_q : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
        last_q <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_sticky_w1c.sv
module spi_sticky_w1c #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic             wr_en_i,
  input  logic             wr_bit_i,
  output logic             q_o
);
  logic any_set;
  assign any_set = |set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    q_o <= 1'b0;
    else if (any_set)              q_o <= 1'b1;
    else if (wr_en_i && wr_bit_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair #(
  parameter int unsigned DEPTH = spi_fifo_pkg::DEFAULT_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_in_valid,
  output logic                rx_in_ready,
  input  spi_fifo_pkg::byte_t rx_in_data,
  output logic                rx_out_valid,
  input  logic                rx_out_ready,
  output spi_fifo_pkg::byte_t rx_out_data,
  output logic [CW-1:0]       rx_count,
  output logic                rx_full,
  output logic                rx_empty,
  input  logic                tx_in_valid,
  output logic                tx_in_ready,
  input  spi_fifo_pkg::byte_t tx_in_data,
  output logic                tx_out_valid,
  input  logic                tx_out_ready,
  output spi_fifo_pkg::byte_t tx_out_data,
  output logic [CW-1:0]       tx_count,
  output logic                tx_full,
  output logic                tx_empty,
  input  logic                ovf_wr_en,
  input  logic                ovf_wr_bit,
  output logic                ovf_flag
);
  logic [1:0] drop;

  spi_byte_fifo #(.DEPTH(DEPTH), .DW(spi_fifo_pkg::BYTE_W)) rx_q_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty), .drop_evt(drop[0])
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .DW(spi_fifo_pkg::BYTE_W)) tx_q_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty), .drop_evt(drop[1])
  );

  spi_sticky_w1c #(.N_SRC(2)) ovf_i (
    .clk(clk), .rst_n(rst_n), .set_i(drop),
    .wr_en_i(ovf_wr_en), .wr_bit_i(ovf_wr_bit), .q_o(ovf_flag)
  );
endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic          rx_out_ready,
  input logic [7:0]    rx_out_data,
  input logic [CW-1:0] rx_count,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          tx_in_valid,
  input logic          tx_in_ready,
  input logic          tx_out_ready,
  input logic [CW-1:0] tx_count,
  input logic          tx_full,
  input logic          ovf_wr_en,
  input logic          ovf_wr_bit,
  input logic          ovf_flag
);
  logic drop_any;
  assign drop_any = (rx_in_valid && !rx_in_ready) || (tx_in_valid && !tx_in_ready);

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));
  // R3
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && rx_in_valid && !rx_out_ready |=> $stable(rx_count) && $stable(rx_out_data));
  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_in_valid && !tx_out_ready |=> $stable(tx_count));
  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(ovf_wr_en && ovf_wr_bit) |=> ovf_flag);
  // R6
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_wr_en && ovf_wr_bit && !drop_any |=> !ovf_flag);
  // R7
  ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_any |=> ovf_flag);
  // R8
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && rx_in_valid && rx_out_ready |=> rx_full);
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && rx_out_ready && !rx_in_valid |=> rx_empty && $stable(rx_out_data));
  // R11
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && !tx_out_ready |=> tx_full);
endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_out_ready(rx_out_ready),
  .rx_out_data(rx_out_data), .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_out_ready(tx_out_ready),
  .tx_count(tx_count), .tx_full(tx_full),
  .ovf_wr_en(ovf_wr_en), .ovf_wr_bit(ovf_wr_bit), .ovf_flag(ovf_flag)
);

// File: tb/spi_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_pair_tb_top;
  localparam int D = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in_valid = 0, rx_out_ready = 0, tx_in_valid = 0, tx_out_ready = 0;
  logic ovf_wr_en = 0, ovf_wr_bit = 0;
  logic [7:0] rx_in_data = 0, tx_in_data = 0;
  logic rx_in_ready, rx_out_valid, rx_full, rx_empty;
  logic tx_in_ready, tx_out_valid, tx_full, tx_empty, ovf_flag;
  logic [7:0] rx_out_data, tx_out_data, rx_count, tx_count;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] mrx[$], mtx[$];
  logic [7:0] last_rx = 0, last_tx = 0;
  bit mflag = 0;

  always #10 clk = ~clk;

  spi_fifo_pair dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty),
    .ovf_wr_en(ovf_wr_en), .ovf_wr_bit(ovf_wr_bit), .ovf_flag(ovf_flag)
  );

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // compare against model, advance model, advance one clock
  task automatic tick();
    bit rpop, racc, tpop, tacc;
    int rs, ts;
    #1;
    rs = mrx.size(); ts = mtx.size();
    cmp("R10 rx_in_ready", rx_in_ready, (rs < D) || rx_out_ready);
    cmp("R10 rx_out_valid", rx_out_valid, rs > 0);
    cmp("R2 rx_out_data", rx_out_data, rs > 0 ? mrx[0] : last_rx);
    cmp("R2 rx_count", rx_count, rs);
    cmp("R11 rx_full", rx_full, rs == D);
    cmp("R9 rx_empty", rx_empty, rs == 0);
    cmp("R10 tx_in_ready", tx_in_ready, (ts < D) || tx_out_ready);
    cmp("R10 tx_out_valid", tx_out_valid, ts > 0);
    cmp("R2 tx_out_data", tx_out_data, ts > 0 ? mtx[0] : last_tx);
    cmp("R2 tx_count", tx_count, ts);
    cmp("R11 tx_full", tx_full, ts == D);
    cmp("R9 tx_empty", tx_empty, ts == 0);
    cmp("R5 ovf_flag", ovf_flag, mflag);
    rpop = rx_out_ready && rs > 0;
    racc = rx_in_valid && (rs < D || rpop);
    tpop = tx_out_ready && ts > 0;
    tacc = tx_in_valid && (ts < D || tpop);
    if (rpop) last_rx = mrx.pop_front();
    if (racc) mrx.push_back(rx_in_data);
    if (tpop) last_tx = mtx.pop_front();
    if (tacc) mtx.push_back(tx_in_data);
    if ((rx_in_valid && !racc) || (tx_in_valid && !tacc)) mflag = 1;
    else if (ovf_wr_en && ovf_wr_bit) mflag = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rx_in_valid = 0; rx_out_ready = 0; tx_in_valid = 0; tx_out_ready = 0;
    ovf_wr_en = 0; ovf_wr_bit = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    cmp("R1 rx_count", rx_count, 0);
    cmp("R1 tx_count", tx_count, 0);
    cmp("R1 rx_empty", rx_empty, 1);
    cmp("R1 tx_empty", tx_empty, 1);
    cmp("R1 ovf_flag", ovf_flag, 0);
    cmp("R1 rx_out_data", rx_out_data, 0);
    cmp("R1 tx_out_data", tx_out_data, 0);

    // R2 fill receive queue
    for (int i = 0; i < D; i++) begin
      rx_in_valid = 1; rx_in_data = 8'(i * 3 + 1); tick();
    end
    idle();
    cmp("R2 rx full after fill", rx_full, 1);

    // R3 push into full receive queue is dropped
    rx_in_valid = 1; rx_in_data = 8'hEE; tick();
    idle(); #1;
    cmp("R3 rx_count after drop", rx_count, D);
    cmp("R3 head unchanged", rx_out_data, 1);
    cmp("R5 flag set by rx drop", ovf_flag, 1);
    // R11 full holds without pops
    repeat (4) tick();
    cmp("R11 rx_full held", rx_full, 1);
    cmp("R5 flag held", ovf_flag, 1);

    // R6 writing 0 keeps flag, writing 1 clears
    ovf_wr_en = 1; ovf_wr_bit = 0; tick(); idle(); #1;
    cmp("R6 write0 no effect", ovf_flag, 1);
    ovf_wr_en = 1; ovf_wr_bit = 1; tick(); idle(); #1;
    cmp("R6 write1 clears", ovf_flag, 0);

    // R8 push and pop together on full receive queue
    for (int i = 0; i < 3; i++) begin
      rx_in_valid = 1; rx_out_ready = 1; rx_in_data = 8'(200 + i); tick();
    end
    idle(); #1;
    cmp("R8 count stays full", rx_count, D);
    cmp("R8 no overflow", ovf_flag, 0);

    // drain receive queue and pop past empty (R9)
    for (int i = 0; i < D + 4; i++) begin
      rx_out_ready = 1; tick();
    end
    idle(); #1;
    cmp("R9 count zero", rx_count, 0);
    cmp("R9 last byte held", rx_out_data, 202);

    // fill transmit queue then overflow with a simultaneous clear (R7, R4)
    for (int i = 0; i < D; i++) begin
      tx_in_valid = 1; tx_in_data = 8'(255 - i); tick();
    end
    tx_in_valid = 1; tx_in_data = 8'h55; ovf_wr_en = 1; ovf_wr_bit = 1; tick();
    idle(); #1;
    cmp("R4 tx write ignored", tx_count, D);
    cmp("R7 set wins over clear", ovf_flag, 1);
    cmp("R11 tx_full held", tx_full, 1);
    tx_out_ready = 1; tick(); idle(); #1;
    cmp("R11 tx_full drops after pop", tx_full, 0);
    ovf_wr_en = 1; ovf_wr_bit = 1; tick(); idle();

    // random mixed traffic against the model
    for (int i = 0; i < 6000; i++) begin
      rx_in_valid  = ($urandom % 100) < 55;
      rx_out_ready = ($urandom % 100) < 45;
      tx_in_valid  = ($urandom % 100) < 45;
      tx_out_ready = ($urandom % 100) < 55;
      rx_in_data   = 8'($urandom);
      tx_in_data   = 8'($urandom);
      ovf_wr_en    = ($urandom % 100) < 5;
      ovf_wr_bit   = $urandom % 2;
      tick();
    end
    idle();
    tick();
    done = 1;
    summary();
  end
endmodule